// File: doc/BRIEF.md
# Delayed Read Prefetch Controller

This block decides, for every delayed read that crosses the bridge, whether the request sent to the target is a prefetch or a single-DWORD fetch. It then builds that master-side request. The inputs are the bus command, the byte address and the byte enables, plus a flag that says the address hit a prefetchable memory window. Three further inputs limit the request: the read-buffer space still free, the cache-line size and the address boundary in force.

A prefetch asks for a burst of whole DWORDs, so every byte enable is turned on. Its length starts from a default set by the command type and is then cut down by the free buffer space and by the distance to the next address boundary. A non-prefetchable read asks for exactly one DWORD and keeps the original byte enables. It also raises a flag that tells the initiator-side target to disconnect after the first data phase.

Each accepted read produces a registered request one clock later. Completion matching, ordering and the bus master itself sit in other blocks.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: The commands memory read line (4'b1110) and memory read multiple (4'b1100) always produce a prefetch (`req_prefetch`=1), whatever `pf_win_hit` is.
- R2: A plain memory read (4'b0110) produces a prefetch only when `pf_win_hit` is 1. With `pf_win_hit` at 0 it produces a single-DWORD request.
- R3: Every other command value produces a single-DWORD request (`req_prefetch`=0).
- R4: For a prefetch, `req_be` is 4'b1111 regardless of `rd_be`.
- R5: For a single-DWORD request, `req_be` equals `rd_be`, `req_dw_cnt` is 1 and `req_single` is 1. For a prefetch, `req_single` is 0.
- R6: The starting prefetch length is `line_dw` DWORDs for memory read line and for a plain memory read inside a window. It is 2×`line_dw` for memory read multiple.
- R7: A prefetch count never exceeds `buf_free_dw` when `buf_free_dw` is nonzero.
- R8: A prefetch count never runs past the boundary. The boundary spans 2^k DWORDs, where k is `bnd_log2` clamped to BND_MAX_LOG (default 10). The DWORDs left before it are 2^k minus (`rd_addr[31:2]` mod 2^k).
- R9: `req_dw_cnt` is at least 1 in every request, even when `line_dw` or `buf_free_dw` is zero. A prefetch count is otherwise the minimum of the limits in R6 to R8.
- R10: Outputs are registered. `req_valid` follows `rd_valid` by one clock, and reset holds `req_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | A delayed read is presented this cycle |
| rd_cmd | input | 4 | Bus command of the read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_be | input | 4 | Active-high byte enables of the read |
| pf_win_hit | input | 1 | Address lies in a prefetchable memory window |
| buf_free_dw | input | CNT_W | Free read-buffer space in DWORDs |
| line_dw | input | CNT_W | Cache-line size in DWORDs |
| bnd_log2 | input | BSEL_W | log2 of the boundary span in DWORDs |
| req_valid | output | 1 | Request to the target is valid |
| req_prefetch | output | 1 | Request is a prefetch |
| req_single | output | 1 | Disconnect the initiator after the first DWORD |
| req_be | output | 4 | Byte enables forwarded to the target |
| req_dw_cnt | output | CNT_W | DWORDs to fetch |

## Verification
The block has a single register stage between the inputs and the outputs. A wrong classification or a wrong length therefore shows at the ports on the clock right after the read is presented, as a wrong prefetch flag, wrong byte enables or a wrong count. The bench presses on the limit crossovers: counts cut by the buffer space, by an address one DWORD before a boundary, by a clamped boundary size, and by zero inputs that must still give one DWORD. A reset synchronizer stuck low would hold `req_valid` at zero, and the first read after reset would expose it.

// File: rtl/rd_pf_pkg.sv
package rd_pf_pkg;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

  typedef enum logic [1:0] {
    RK_SINGLE   = 2'd0,
    RK_ONE_LINE = 2'd1,
    RK_TWO_LINE = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/rd_pf_rst_sync.sv
module rd_pf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/rd_pf_classify.sv
module rd_pf_classify
  import rd_pf_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       win_hit,
  output rd_kind_e   kind
);
  always_comb begin
    unique case (cmd)
      CMD_MEM_RD_LINE: kind = RK_ONE_LINE;
      CMD_MEM_RD_MULT: kind = RK_TWO_LINE;
      CMD_MEM_RD:      kind = win_hit ? RK_ONE_LINE : RK_SINGLE;
      default:         kind = RK_SINGLE;
    endcase
  end
endmodule

// File: rtl/rd_pf_len_calc.sv
module rd_pf_len_calc
  import rd_pf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BND_MAX_LOG = 10,
  parameter int BSEL_W      = 4
) (
  input  rd_kind_e                 kind,
  input  logic [BND_MAX_LOG-1:0]   dw_low,
  input  logic [CNT_W-1:0]         free_dw,
  input  logic [CNT_W-1:0]         line_dw,
  input  logic [BSEL_W-1:0]        bnd_log2,
  output logic [CNT_W-1:0]         fetch_cnt
);
  localparam int W = ((CNT_W + 1) > (BND_MAX_LOG + 1)) ? (CNT_W + 1) : (BND_MAX_LOG + 1);
  localparam logic [BSEL_W-1:0] K_MAX = BSEL_W'(BND_MAX_LOG);

  logic [BSEL_W-1:0] k_eff;
  logic [W-1:0]      span, offset, remain, dflt, free_w, min_a, min_b;

  always_comb begin
    k_eff  = (bnd_log2 > K_MAX) ? K_MAX : bnd_log2;
    span   = W'(1) << k_eff;
    offset = W'(dw_low) & (span - W'(1));
    remain = span - offset;
    dflt   = (kind == RK_TWO_LINE) ? (W'(line_dw) << 1) : W'(line_dw);
    free_w = W'(free_dw);
    min_a  = (dflt < free_w) ? dflt : free_w;
    min_b  = (min_a < remain) ? min_a : remain;
    if (kind == RK_SINGLE || min_b == '0) fetch_cnt = CNT_W'(1);
    else                                  fetch_cnt = CNT_W'(min_b);
  end
endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
  import rd_pf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 8,
  parameter int BND_MAX_LOG = 10,
  parameter int BSEL_W      = $clog2(BND_MAX_LOG + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [3:0]        rd_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [3:0]        rd_be,
  input  logic              pf_win_hit,
  input  logic [CNT_W-1:0]  buf_free_dw,
  input  logic [CNT_W-1:0]  line_dw,
  input  logic [BSEL_W-1:0] bnd_log2,
  output logic              req_valid,
  output logic              req_prefetch,
  output logic              req_single,
  output logic [3:0]        req_be,
  output logic [CNT_W-1:0]  req_dw_cnt
);
  logic       core_rst_n;
  rd_kind_e   kind;
  logic [CNT_W-1:0] cnt_d;
  logic       pf_d, single_d;
  logic [3:0] be_d;

  rd_pf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_out_n(core_rst_n)
  );

  rd_pf_classify u_cls (
    .cmd(rd_cmd), .win_hit(pf_win_hit), .kind(kind)
  );

  rd_pf_len_calc #(.CNT_W(CNT_W), .BND_MAX_LOG(BND_MAX_LOG), .BSEL_W(BSEL_W)) u_len (
    .kind(kind), .dw_low(rd_addr[2 +: BND_MAX_LOG]), .free_dw(buf_free_dw),
    .line_dw(line_dw), .bnd_log2(bnd_log2), .fetch_cnt(cnt_d)
  );

  always_comb begin
    pf_d     = (kind != RK_SINGLE);
    single_d = ~pf_d;
    be_d     = pf_d ? 4'b1111 : rd_be;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      req_valid    <= 1'b0;
      req_prefetch <= 1'b0;
      req_single   <= 1'b0;
      req_be       <= '0;
      req_dw_cnt   <= '0;
    end else begin
      req_valid <= rd_valid;
      if (rd_valid) begin
        req_prefetch <= pf_d;
        req_single   <= single_d;
        req_be       <= be_d;
        req_dw_cnt   <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/rd_pf_chk.sv
module rd_pf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic [3:0]       rd_cmd,
  input logic [3:0]       rd_be,
  input logic             pf_win_hit,
  input logic [CNT_W-1:0] buf_free_dw,
  input logic             req_valid,
  input logic             req_prefetch,
  input logic             req_single,
  input logic [3:0]       req_be,
  input logic [CNT_W-1:0] req_dw_cnt
);
  a_r1_line_mult_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && (rd_cmd == 4'b1110 || rd_cmd == 4'b1100) |=> req_prefetch);

  a_r2_plain_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_cmd == 4'b0110 |=> req_prefetch == $past(pf_win_hit));

  a_r4_prefetch_all_be: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_prefetch |-> req_be == 4'b1111);

  a_r5_single_one_dw: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_single |-> req_dw_cnt == CNT_W'(1) && !req_prefetch);

  a_r5_single_keeps_be: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !(rd_cmd == 4'b1110 || rd_cmd == 4'b1100 || (rd_cmd == 4'b0110 && pf_win_hit))
    |=> req_be == $past(rd_be) && req_single);

  a_r7_within_free: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && buf_free_dw != '0 |=> req_dw_cnt <= $past(buf_free_dw));

  a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_dw_cnt != '0);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> req_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !req_valid);
endmodule

bind rd_prefetch_ctrl rd_pf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .rd_valid(rd_valid), .rd_cmd(rd_cmd),
  .rd_be(rd_be), .pf_win_hit(pf_win_hit), .buf_free_dw(buf_free_dw),
  .req_valid(req_valid), .req_prefetch(req_prefetch), .req_single(req_single),
  .req_be(req_be), .req_dw_cnt(req_dw_cnt)
);

// File: tb/sim_rd_prefetch_ctrl.sv
module sim_rd_prefetch_ctrl;
  localparam int CLK_P   = 10;
  localparam int CNT_W   = 8;
  localparam int BMAX    = 10;
  localparam int BSEL_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic rd_valid;
  logic [3:0] rd_cmd;
  logic [31:0] rd_addr;
  logic [3:0] rd_be;
  logic pf_win_hit;
  logic [CNT_W-1:0] buf_free_dw, line_dw;
  logic [BSEL_W-1:0] bnd_log2;
  logic req_valid, req_prefetch, req_single;
  logic [3:0] req_be;
  logic [CNT_W-1:0] req_dw_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int    q_valid[$];
  int    q_pf[$];
  int    q_be[$];
  int    q_cnt[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  rd_prefetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_cmd(rd_cmd),
    .rd_addr(rd_addr), .rd_be(rd_be), .pf_win_hit(pf_win_hit),
    .buf_free_dw(buf_free_dw), .line_dw(line_dw), .bnd_log2(bnd_log2),
    .req_valid(req_valid), .req_prefetch(req_prefetch), .req_single(req_single),
    .req_be(req_be), .req_dw_cnt(req_dw_cnt)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // compare the previous step's prediction, then drive the next step
  task automatic step(bit v, logic [3:0] cmd, int addr, logic [3:0] be, bit hit,
                      int free, int line, int bnd, string tag);
    @(negedge clk);
    if (q_valid.size() > 0) begin
      int ev = q_valid.pop_front();
      int ep = q_pf.pop_front();
      int eb = q_be.pop_front();
      int ec = q_cnt.pop_front();
      string et = q_tag.pop_front();
      check("R10", "req_valid", int'(req_valid), ev);
      if (ev != 0) begin
        check(et, "req_prefetch", int'(req_prefetch), ep);
        check(ep != 0 ? "R5" : et, "req_single", int'(req_single), ep != 0 ? 0 : 1);
        check(ep != 0 ? "R4" : "R5", "req_be", int'(req_be), eb);
        check(et, "req_dw_cnt", int'(req_dw_cnt), ec);
      end
    end
    rd_valid = v; rd_cmd = cmd; rd_addr = addr; rd_be = be; pf_win_hit = hit;
    buf_free_dw = CNT_W'(free); line_dw = CNT_W'(line); bnd_log2 = BSEL_W'(bnd);
    begin
      bit pf = (cmd == 4'b1110) || (cmd == 4'b1100) || (cmd == 4'b0110 && hit);
      int k = (bnd > BMAX) ? BMAX : bnd;
      int span = 1 << k;
      int rem = span - ((addr >>> 2) & (span - 1));
      int dflt = (cmd == 4'b1100) ? 2 * line : line;
      int c = dflt;
      if (free < c) c = free;
      if (rem < c) c = rem;
      if (!pf || c < 1) c = 1;
      q_valid.push_back(v);
      q_pf.push_back(pf);
      q_be.push_back(pf ? 15 : int'(be));
      q_cnt.push_back(c);
      q_tag.push_back(tag);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    rd_valid = 0; rd_cmd = 0; rd_addr = 0; rd_be = 0; pf_win_hit = 0;
    buf_free_dw = 0; line_dw = 0; bnd_log2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 4'h0, 0, 4'h0, 0, 0, 0, 0, "R10");

    step(1, 4'b1110, 32'h0000_1000, 4'b0011, 0, 200, 8, 10, "R1");
    step(1, 4'b1100, 32'h0000_1000, 4'b0101, 0, 200, 8, 10, "R6");
    step(1, 4'b0110, 32'h0000_2000, 4'b0110, 1, 200, 16, 10, "R2");
    step(1, 4'b0110, 32'h0000_2000, 4'b0110, 0, 200, 16, 10, "R2");
    step(0, 4'b1110, 0, 4'h0, 0, 200, 8, 10, "R10");
    step(1, 4'b1010, 32'h0000_0040, 4'b1001, 1, 200, 8, 10, "R3");
    step(1, 4'b0010, 32'h0000_0044, 4'b0001, 1, 200, 8, 10, "R3");
    step(1, 4'b1100, 32'h0000_0000, 4'b0000, 0, 5, 8, 10, "R7");
    step(1, 4'b1110, 32'h0000_0FFC, 4'b0000, 0, 200, 8, 10, "R8");
    step(1, 4'b1100, 32'h0000_003C, 4'b0000, 0, 200, 32, 4, "R8");
    step(1, 4'b1100, 32'h0000_0040, 4'b0000, 0, 200, 32, 4, "R8");
    step(1, 4'b1100, 32'h0000_3FF0, 4'b0000, 0, 255, 100, 15, "R8");
    step(1, 4'b1110, 32'h0000_0000, 4'b0000, 0, 0, 8, 10, "R9");
    step(1, 4'b1110, 32'h0000_0000, 4'b0000, 0, 100, 0, 10, "R9");
    step(1, 4'b1100, 32'h0000_0000, 4'b0000, 0, 255, 200, 0, "R9");

    for (int i = 0; i < 300; i++) begin
      logic [3:0] cmds [6] = '{4'b0110, 4'b1100, 4'b1110, 4'b1010, 4'b0010, 4'b0111};
      step(bit'($urandom_range(0, 4) != 0), cmds[$urandom_range(0, 5)],
           int'($urandom_range(0, 32'h0000_FFFF)) & ~3, 4'($urandom),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 40)), int'($urandom_range(0, 15)), "R6");
    end
    step(0, 4'h0, 0, 4'h0, 0, 0, 0, 0, "R10");
    finish_run();
  end
endmodule